// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller With Interrupts

A register-mapped controller for a bank of general-purpose pins. Software programs it over a simple single-cycle register bus. A direction register decides, for each pin, whether the pin is driven. An output register supplies the driven values. Two write-only ports set or clear selected output bits without a read-modify-write.

The input pins are brought into the clock domain by a two-flop synchronizer. A sampled copy of the pins can be read back. Each pin can raise an interrupt in one of two ways:

- **Level mode:** on a high or a low level.
- **Edge mode:** on a rising edge, a falling edge, or both, chosen by two independent enables.

Edge events are held in a raw pending register until software clears them. A pin reaches the masked status, and the single interrupt line, only when its mask bit is 0 and its enable bit is 1.

The register bus has no back-pressure. A write is taken in the cycle that the write enable is high. Read data appears on the cycle after the read enable and holds until the next read. No stream interface exists, because all traffic is single register accesses.

Top module: `pbk_ctrl`

## Requirements
- R1: Registers are read and written at these byte addresses:
  - direction 0x00, level-select 0x04, level-polarity 0x08
  - rising enable 0x0C, falling enable 0x10
  - output data 0x20, mask 0x28, enable 0x2C

  Each read returns the last value written. Read data appears one cycle after the read enable. An address outside the map reads 0, and a write to it changes nothing.
- R2: Each pin's output enable equals its direction bit (1 = output, 0 = input). Each output pin value equals its output data bit.
- R3: A write to 0x18 forces to 1 every output data bit written as 1 and leaves the rest unchanged. A write to 0x1C forces those bits to 0 instead. Both addresses read back as 0.
- R4: A read of 0x14 returns the pin levels after two synchronizer flops. A write to 0x14 has no effect.
- R5: With its level-select bit at 0, a pin latches a pending event on a 0-to-1 change when its rising enable is 1, and on a 1-to-0 change when its falling enable is 1. With both enables set it latches on either change. An event stays latched until cleared.
- R6: With its level-select bit at 1, a pin's pending bit follows the synchronized level: active high when its polarity bit is 1, active low when it is 0. A clear does not remove a level that is still active.
- R7: The masked status at 0x30 is pending AND NOT mask AND enable, bit by bit.
- R8: A write to 0x34 clears the edge pending bits written as 1 and leaves the others. An edge event arriving in the same cycle as its clear keeps the bit set.
- R9: The interrupt output is 1 exactly when any masked status bit is 1.
- R10: After reset the mask register reads 0xFFFF. Every other register, the output enables and the interrupt output read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rd_en | input | 1 | Read strobe; data follows one cycle later |
| bus_rdata | output | 16 | Read data, held until the next read |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| pin_out | output | 16 | Values to drive on output pins |
| pin_oe | output | 16 | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
An edge event on a pin and a software clear of that same pending bit can reach the pending register on the same clock edge. Whether the event or the clear wins decides if an interrupt is lost.

The bench provokes the collision deliberately. It changes the pin on a falling clock edge, then counts the synchronizer stages and the edge comparison so that the clear write is sampled on the edge where the event is seen. It then reads the masked status and expects the bit still set.

A second pass sends a clear with no event and expects the bit gone. This shows that the clear path works and that the first result came from the collision.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

  // byte offsets of the register window
  localparam int OFS_DIR  = 'h00;
  localparam int OFS_LSEL = 'h04;
  localparam int OFS_LPOL = 'h08;
  localparam int OFS_RISE = 'h0C;
  localparam int OFS_FALL = 'h10;
  localparam int OFS_DIN  = 'h14;
  localparam int OFS_SET  = 'h18;
  localparam int OFS_CLR  = 'h1C;
  localparam int OFS_OUT  = 'h20;
  localparam int OFS_MASK = 'h28;
  localparam int OFS_EN   = 'h2C;
  localparam int OFS_STAT = 'h30;
  localparam int OFS_ICLR = 'h34;

  typedef struct packed {
    logic dir;
    logic lsel;
    logic lpol;
    logic rise;
    logic fall;
    logic set;
    logic clr;
    logic out;
    logic mask;
    logic en;
    logic iclr;
  } wstb_t;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_LSEL,
    SEL_LPOL,
    SEL_RISE,
    SEL_FALL,
    SEL_DIN,
    SEL_OUT,
    SEL_MASK,
    SEL_EN,
    SEL_STAT
  } rsel_t;

endpackage

// File: rtl/pbk_decode.sv
module pbk_decode
  import pbk_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output wstb_t             stb,
  output rsel_t             rsel
);

  always_comb begin
    stb  = '0;
    rsel = SEL_NONE;
    case (addr)
      ADDR_W'(OFS_DIR):  begin stb.dir  = wr_en; rsel = SEL_DIR;  end
      ADDR_W'(OFS_LSEL): begin stb.lsel = wr_en; rsel = SEL_LSEL; end
      ADDR_W'(OFS_LPOL): begin stb.lpol = wr_en; rsel = SEL_LPOL; end
      ADDR_W'(OFS_RISE): begin stb.rise = wr_en; rsel = SEL_RISE; end
      ADDR_W'(OFS_FALL): begin stb.fall = wr_en; rsel = SEL_FALL; end
      ADDR_W'(OFS_DIN):  begin rsel = SEL_DIN; end
      ADDR_W'(OFS_SET):  begin stb.set  = wr_en; end
      ADDR_W'(OFS_CLR):  begin stb.clr  = wr_en; end
      ADDR_W'(OFS_OUT):  begin stb.out  = wr_en; rsel = SEL_OUT;  end
      ADDR_W'(OFS_MASK): begin stb.mask = wr_en; rsel = SEL_MASK; end
      ADDR_W'(OFS_EN):   begin stb.en   = wr_en; rsel = SEL_EN;   end
      ADDR_W'(OFS_STAT): begin rsel = SEL_STAT; end
      ADDR_W'(OFS_ICLR): begin stb.iclr = wr_en; end
      default:           begin rsel = SEL_NONE; end
    endcase
  end

endmodule

// File: rtl/pbk_regs.sv
module pbk_regs
  import pbk_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wstb_t        stb,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lsel_q,
  output logic [N-1:0] lpol_q,
  output logic [N-1:0] rise_q,
  output logic [N-1:0] fall_q,
  output logic [N-1:0] out_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lsel_q <= '0;
      lpol_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
    end else begin
      if (stb.dir)  dir_q  <= wdata;
      if (stb.lsel) lsel_q <= wdata;
      if (stb.lpol) lpol_q <= wdata;
      if (stb.rise) rise_q <= wdata;
      if (stb.fall) fall_q <= wdata;
      if (stb.mask) mask_q <= wdata;
      if (stb.en)   en_q   <= wdata;
    end
  end

  // output data: plain write, or atomic set / clear of selected bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (stb.out) begin
      out_q <= wdata;
    end else if (stb.set) begin
      out_q <= out_q | wdata;
    end else if (stb.clr) begin
      out_q <= out_q & ~wdata;
    end
  end

endmodule

// File: rtl/pbk_sync_detect.sv
module pbk_sync_detect #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  localparam int LAST = STAGES - 1;

  logic [N-1:0] chain_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= pin_in;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[LAST];
    end
  end

  assign level = chain_q[LAST];
  assign rise  = chain_q[LAST] & ~prev_q;
  assign fall  = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/pbk_irq.sv
module pbk_irq #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic [N-1:0] lsel,
  input  logic [N-1:0] lpol,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] en,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] pend,
  output logic [N-1:0] masked,
  output logic         irq
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic bit_q;
    logic event_d;
    logic active_d;
    logic clear_d;

    assign event_d  = (rise[g] & rise_en[g]) | (fall[g] & fall_en[g]);
    assign active_d = lpol[g] ? level[g] : ~level[g];
    assign clear_d  = clr_we & clr_data[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (lsel[g]) begin
        bit_q <= active_d;
      end else begin
        // a fresh event outranks a clear in the same cycle
        bit_q <= event_d | (bit_q & ~clear_d);
      end
    end

    assign pend[g] = bit_q;
  end

  assign masked = pend & ~mask & en;
  assign irq    = |masked;

endmodule

// File: rtl/pbk_ctrl.sv
module pbk_ctrl
  import pbk_pkg::*;
#(
  parameter int N      = 16,
  parameter int ADDR_W = 6,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [N-1:0]      bus_wdata,
  input  logic              bus_rd_en,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq_out
);

  wstb_t        stb;
  rsel_t        rsel;
  logic [N-1:0] dir_q, lsel_q, lpol_q, rise_q, fall_q, out_q, mask_q, en_q;
  logic [N-1:0] level, rise, fall;
  logic [N-1:0] pend_q, masked;
  logic [N-1:0] rd_mux;

  pbk_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr  (bus_addr),
    .wr_en (bus_wr_en),
    .stb   (stb),
    .rsel  (rsel)
  );

  pbk_regs #(.N(N)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .lsel_q (lsel_q),
    .lpol_q (lpol_q),
    .rise_q (rise_q),
    .fall_q (fall_q),
    .out_q  (out_q),
    .mask_q (mask_q),
    .en_q   (en_q)
  );

  pbk_sync_detect #(.N(N), .STAGES(STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .level  (level),
    .rise   (rise),
    .fall   (fall)
  );

  pbk_irq #(.N(N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level),
    .rise     (rise),
    .fall     (fall),
    .lsel     (lsel_q),
    .lpol     (lpol_q),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .mask     (mask_q),
    .en       (en_q),
    .clr_we   (stb.iclr),
    .clr_data (bus_wdata),
    .pend     (pend_q),
    .masked   (masked),
    .irq      (irq_out)
  );

  always_comb begin
    case (rsel)
      SEL_DIR:  rd_mux = dir_q;
      SEL_LSEL: rd_mux = lsel_q;
      SEL_LPOL: rd_mux = lpol_q;
      SEL_RISE: rd_mux = rise_q;
      SEL_FALL: rd_mux = fall_q;
      SEL_DIN:  rd_mux = level;
      SEL_OUT:  rd_mux = out_q;
      SEL_MASK: rd_mux = mask_q;
      SEL_EN:   rd_mux = en_q;
      SEL_STAT: rd_mux = masked;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/pbk_chk.sv
module pbk_chk
  import pbk_pkg::*;
#(
  parameter int N      = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      pin_out,
  input logic [N-1:0]      pin_oe,
  input logic              irq_out,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      lsel_q,
  input logic [N-1:0]      pend_q
);

  logic         wr_dir, wr_set, wr_clr;
  logic [N-1:0] clr_bits;

  assign wr_dir   = bus_wr_en && (bus_addr == ADDR_W'(OFS_DIR));
  assign wr_set   = bus_wr_en && (bus_addr == ADDR_W'(OFS_SET));
  assign wr_clr   = bus_wr_en && (bus_addr == ADDR_W'(OFS_CLR));
  assign clr_bits = (bus_wr_en && (bus_addr == ADDR_W'(OFS_ICLR))) ? bus_wdata : '0;

  // R2
  dir_drives_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(bus_wdata)));

  // R3
  set_port_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (pin_out == ($past(pin_out) | $past(bus_wdata))));

  // R3
  clr_port_andn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (pin_out == ($past(pin_out) & ~$past(bus_wdata))));

  // R5
  edge_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(lsel_q) & ~$past(clr_bits)) & ~pend_q) == '0));

  // R9
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_out);

  // R9
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_q != '0));

endmodule

bind pbk_ctrl pbk_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr_en (bus_wr_en),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_out   (irq_out),
  .mask_q    (mask_q),
  .lsel_q    (lsel_q),
  .pend_q    (pend_q)
);

// File: tb/pbk_ctrl_bench.sv
module pbk_ctrl_bench;

  localparam int N      = 16;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic [N-1:0]      bus_wdata = '0;
  logic              bus_rd_en = 1'b0;
  logic [N-1:0]      bus_rdata;
  logic [N-1:0]      pin_in = '0;
  logic [N-1:0]      pin_out;
  logic [N-1:0]      pin_oe;
  logic              irq_out;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pbk_ctrl #(.N(N), .ADDR_W(ADDR_W)) u_pbk_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rd_en (bus_rd_en),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out)
  );

  // {write address, write data, read address, expected read}
  localparam logic [63:0] VEC [13] = '{
    64'h0000_A5C3_0000_A5C3,   // R1 direction
    64'h0004_0000_0004_0000,   // R1 level-select
    64'h0008_F00F_0008_F00F,   // R1 polarity
    64'h000C_1234_000C_1234,   // R1 rising enable
    64'h0010_8001_0010_8001,   // R1 falling enable
    64'h0020_00F0_0020_00F0,   // R1 output data
    64'h0018_0F01_0020_0FF1,   // R3 set port
    64'h001C_00F0_0020_0F01,   // R3 clear port
    64'h0018_FFFF_0018_0000,   // R3 set port reads 0
    64'h0014_FFFF_0014_0000,   // R4 write to data-in ignored
    64'h0024_BEEF_0024_0000,   // R1 unmapped address
    64'h002C_00FF_002C_00FF,   // R1 enable
    64'h0028_0F0F_0028_0F0F    // R1 mask
  };

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    pin_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rd;

    do_reset();

    // R10: reset values
    bus_read(6'h28, rd); check("R10 mask reset", rd, 16'hFFFF);
    bus_read(6'h00, rd); check("R10 direction reset", rd, 16'h0000);
    bus_read(6'h2C, rd); check("R10 enable reset", rd, 16'h0000);
    check("R10 oe reset", pin_oe, 16'h0000);
    check("R10 irq reset", {15'd0, irq_out}, 16'h0000);

    // table walk: R1, R3, R4
    foreach (VEC[i]) begin
      bus_write(VEC[i][63+(ADDR_W-16):48], VEC[i][47:32]);
      bus_read(VEC[i][31+(ADDR_W-16):16], rd);
      check($sformatf("table vector %0d", i), rd, VEC[i][15:0]);
    end

    do_reset();

    // R2: pins follow direction and output data
    bus_write(6'h00, 16'h00FF);
    bus_write(6'h20, 16'h0F0F);
    check("R2 oe", pin_oe, 16'h00FF);
    check("R2 out", pin_out, 16'h0F0F);

    // R5: rising only on pin 0
    bus_write(6'h0C, 16'h0001);
    bus_write(6'h28, 16'hFFFE);
    bus_write(6'h2C, 16'h0001);
    @(negedge clk); pin_in[0] = 1'b1;
    idle(4);
    bus_read(6'h30, rd); check("R5 rising latched", rd, 16'h0001);
    check("R9 irq on", {15'd0, irq_out}, 16'h0001);
    bus_write(6'h34, 16'h0001);
    bus_read(6'h30, rd); check("R8 cleared", rd, 16'h0000);
    check("R9 irq off", {15'd0, irq_out}, 16'h0000);
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);
    bus_read(6'h30, rd); check("R5 fall ignored in rising mode", rd, 16'h0000);

    // R5: falling only on pin 1
    bus_write(6'h0C, 16'h0000);
    bus_write(6'h10, 16'h0002);
    bus_write(6'h28, 16'hFFFD);
    bus_write(6'h2C, 16'h0002);
    @(negedge clk); pin_in[1] = 1'b1;
    idle(4);
    bus_read(6'h30, rd); check("R5 rise ignored in falling mode", rd, 16'h0000);
    @(negedge clk); pin_in[1] = 1'b0;
    idle(4);
    bus_read(6'h30, rd); check("R5 falling latched", rd, 16'h0002);
    bus_write(6'h34, 16'h0001);
    bus_read(6'h30, rd); check("R8 other bit kept", rd, 16'h0002);
    bus_write(6'h34, 16'h0002);
    bus_write(6'h10, 16'h0000);

    // R7: gating by mask and enable on pin 4
    bus_write(6'h0C, 16'h0010);
    bus_write(6'h28, 16'hFFFF);
    bus_write(6'h2C, 16'h0010);
    @(negedge clk); pin_in[4] = 1'b1;
    idle(4);
    bus_read(6'h30, rd); check("R7 masked bit hidden", rd, 16'h0000);
    bus_write(6'h28, 16'hFFEF);
    bus_write(6'h2C, 16'h0000);
    bus_read(6'h30, rd); check("R7 disabled bit hidden", rd, 16'h0000);
    check("R9 irq quiet when gated", {15'd0, irq_out}, 16'h0000);
    bus_write(6'h2C, 16'h0010);
    bus_read(6'h30, rd); check("R7 both gates open", rd, 16'h0010);
    bus_write(6'h34, 16'h0010);
    bus_write(6'h0C, 16'h0000);

    // R6: level high on pin 2
    bus_write(6'h04, 16'h0004);
    bus_write(6'h08, 16'h0004);
    bus_write(6'h28, 16'hFFFB);
    bus_write(6'h2C, 16'h0004);
    @(negedge clk); pin_in[2] = 1'b1;
    idle(4);
    bus_read(6'h30, rd); check("R6 level high seen", rd, 16'h0004);
    bus_write(6'h34, 16'h0004);
    idle(2);
    bus_read(6'h30, rd); check("R6 clear while active", rd, 16'h0004);
    @(negedge clk); pin_in[2] = 1'b0;
    idle(4);
    bus_read(6'h30, rd); check("R6 level gone", rd, 16'h0000);

    // R6: level low on pin 3
    bus_write(6'h04, 16'h0008);
    bus_write(6'h08, 16'h0000);
    bus_write(6'h28, 16'hFFF7);
    bus_write(6'h2C, 16'h0008);
    idle(2);
    bus_read(6'h30, rd); check("R6 level low seen", rd, 16'h0008);
    @(negedge clk); pin_in[3] = 1'b1;
    idle(4);
    bus_read(6'h30, rd); check("R6 low level released", rd, 16'h0000);
    bus_write(6'h04, 16'h0000);

    // R5/R8: both edges on pin 5, event and clear in the same cycle
    bus_write(6'h0C, 16'h0020);
    bus_write(6'h10, 16'h0020);
    bus_write(6'h28, 16'hFFDF);
    bus_write(6'h2C, 16'h0020);
    @(negedge clk); pin_in[5] = 1'b1;
    idle(4);
    bus_read(6'h30, rd); check("R5 both-edge rise", rd, 16'h0020);
    @(negedge clk); pin_in[5] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr  = 6'h34;
    bus_wdata = 16'h0020;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    idle(2);
    bus_read(6'h30, rd); check("R8 event beats clear", rd, 16'h0020);
    bus_write(6'h34, 16'h0020);
    bus_read(6'h30, rd); check("R8 plain clear", rd, 16'h0000);

    // R4: sampled pins
    @(negedge clk); pin_in = 16'hA5C0;
    idle(3);
    bus_read(6'h14, rd); check("R4 data-in", rd, 16'hA5C0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule